// File: doc/BRIEF.md
# I2C Event Flag and Status Unit

This block is the control core that sits between an I2C bus front end and software. Whenever the front end reports a bus event that software must act on, the block raises an interrupt flag and, one clock later, publishes an 8-bit status code naming that event. While the flag is up, the block asks the bus to keep SCL low. This stalls the transfer until software has read the status and acknowledged it.

Software acknowledges an event by writing a one to the flag. This drops the flag and releases SCL on the next cycle. The block also watches the bus itself for a lost arbitration during a master transmission. It reports that loss as an event of its own. While the flag is clear, the status register carries a fixed code that means no information is available, so a stale code can never be read.

Top module: `i2c_evt_status`

## Requirements
- R1: When the flag is clear and `evt_valid_i` is high at a clock edge, `irq_flag_o` is high from that edge on.
- R2: In the cycle the flag rises, `status_o` still reads 8'hF8. From the next edge, it reads the event's code: kind 0 start sent 8'h08, 1 repeated start sent 8'h10, 2 address ACK 8'h18, 3 address NACK 8'h20, 4 data ACK 8'h28, 5 data NACK 8'h30, 6 own address matched 8'h60, 7 stop seen 8'hA0.
- R3: Whenever `irq_flag_o` is low, `status_o` reads 8'hF8.
- R4: Once set, the flag stays high until software clears it, and `scl_hold_o` is high in every cycle the flag is high.
- R5: A one on `flag_clr_i` with no event in the same cycle drops the flag and `scl_hold_o` at the next edge. A clear while the flag is already low changes nothing.
- R6: An event in the same cycle as a clear wins. The flag stays high, `status_o` reads 8'hF8 for one cycle, then shows the new event's code.
- R7: With the flag clear, arbitration loss is seen when `master_tx_i`, `sda_rel_i` and `scl_i` are high and `sda_i` is low. It sets the flag with status code 8'h38. It takes priority over a front-end strobe in the same cycle. No other combination of these four inputs raises the flag.
- R8: An event that arrives while the flag is high and no clear is written is ignored, and the published code is kept.
- R9: The low 3 bits of `status_o` are always zero. The code lives in the upper 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Front-end event strobe |
| evt_kind_i | input | 3 | Event kind, see R2 |
| flag_clr_i | input | 1 | Software write-one-to-clear of the flag |
| master_tx_i | input | 1 | Block is transmitting as master |
| sda_rel_i | input | 1 | Block is releasing SDA high |
| sda_i | input | 1 | Sampled SDA level |
| scl_i | input | 1 | Sampled SCL level |
| irq_flag_o | output | 1 | Interrupt flag |
| scl_hold_o | output | 1 | Request to hold SCL low |
| status_o | output | 8 | Status code |

## Verification
The assertions check several rules on every cycle: the idle code is shown whenever the flag is low, the code follows one cycle after the flag rises, the flag holds until cleared, a plain clear releases the hold, arbitration loss is captured, and the low status bits stay zero. Only the bench scenarios show that each of the eight event kinds maps to its own code value. The same goes for the exact two-cycle order of a clear colliding with a new event, for events dropped while the flag is held, and for the full sweep of the four arbitration inputs, where only one combination may raise the flag.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int KIND_W   = 3;
  localparam int STAT_W   = 8;
  localparam int CODE_LSB = 3;
  localparam int HI_W     = STAT_W - CODE_LSB;

  typedef enum logic [KIND_W-1:0] {
    EV_START    = 3'd0,
    EV_RSTART   = 3'd1,
    EV_ADDR_ACK = 3'd2,
    EV_ADDR_NAK = 3'd3,
    EV_DATA_ACK = 3'd4,
    EV_DATA_NAK = 3'd5,
    EV_OWN_ADDR = 3'd6,
    EV_STOP     = 3'd7
  } evt_kind_e;

  localparam logic [HI_W-1:0] HI_IDLE = '1;
  localparam logic [HI_W-1:0] HI_ARB  = HI_W'(7);
  localparam logic [STAT_W-1:0] STAT_IDLE = {HI_IDLE, {CODE_LSB{1'b0}}};
  localparam logic [STAT_W-1:0] STAT_ARB  = {HI_ARB, {CODE_LSB{1'b0}}};

  function automatic logic [HI_W-1:0] kind_hi(evt_kind_e k);
    case (k)
      EV_START:    kind_hi = HI_W'(1);
      EV_RSTART:   kind_hi = HI_W'(2);
      EV_ADDR_ACK: kind_hi = HI_W'(3);
      EV_ADDR_NAK: kind_hi = HI_W'(4);
      EV_DATA_ACK: kind_hi = HI_W'(5);
      EV_DATA_NAK: kind_hi = HI_W'(6);
      EV_OWN_ADDR: kind_hi = HI_W'(12);
      default:     kind_hi = HI_W'(20);
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] to_stat(logic [HI_W-1:0] hi);
    to_stat = {hi, {CODE_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/i2c_arb_detect.sv
module i2c_arb_detect (
  input  logic master_tx_i,
  input  logic sda_rel_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic arb_lost_o
);
  // released high, but another master pulls it low during SCL high
  assign arb_lost_o = master_tx_i & sda_rel_i & ~sda_i & scl_i;
endmodule

// File: rtl/i2c_evt_select.sv
module i2c_evt_select
  import i2c_evt_pkg::*;
(
  input  logic                  evt_valid_i,
  input  logic [KIND_W-1:0]     evt_kind_i,
  input  logic                  arb_lost_i,
  input  logic                  armed_i,
  output logic                  load_o,
  output logic [STAT_W-1:0]     code_o
);
  logic [HI_W-1:0] hi;

  always_comb begin
    if (arb_lost_i) hi = HI_ARB;
    else            hi = kind_hi(evt_kind_e'(evt_kind_i));
  end

  assign load_o = armed_i & (arb_lost_i | evt_valid_i);
  assign code_o = to_stat(hi);
endmodule

// File: rtl/i2c_flag_status.sv
module i2c_flag_status
  import i2c_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [STAT_W-1:0] code_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [STAT_W-1:0] status_o
);
  logic              flag_q, flag_d;
  logic [STAT_W-1:0] code_q, status_q, status_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)  flag_d = 1'b0;
    if (load_i) flag_d = 1'b1;
    // code is published one cycle after the flag; idle code otherwise
    status_d = (flag_q && flag_d && !load_i) ? code_q : STAT_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      code_q   <= STAT_IDLE;
      status_q <= STAT_IDLE;
    end else begin
      flag_q   <= flag_d;
      status_q <= status_d;
      if (load_i) code_q <= code_i;
    end
  end

  assign flag_o   = flag_q;
  assign status_o = status_q;

  AST_IDLE_WHEN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q |-> status_q == STAT_IDLE); // R3
  AST_CODE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |=> (!flag_q || status_q == $past(code_q))); // R2
  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q && $stable(code_q)); // R4
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q[CODE_LSB-1:0] == '0); // R9
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [KIND_W-1:0] evt_kind_i,
  input  logic              flag_clr_i,
  input  logic              master_tx_i,
  input  logic              sda_rel_i,
  input  logic              sda_i,
  input  logic              scl_i,
  output logic              irq_flag_o,
  output logic              scl_hold_o,
  output logic [STAT_W-1:0] status_o
);
  logic              arb_lost, load, flag;
  logic [STAT_W-1:0] code;

  i2c_arb_detect u_arb (
    .master_tx_i(master_tx_i),
    .sda_rel_i  (sda_rel_i),
    .sda_i      (sda_i),
    .scl_i      (scl_i),
    .arb_lost_o (arb_lost)
  );

  i2c_evt_select u_sel (
    .evt_valid_i(evt_valid_i),
    .evt_kind_i (evt_kind_i),
    .arb_lost_i (arb_lost),
    .armed_i    (!flag || flag_clr_i),
    .load_o     (load),
    .code_o     (code)
  );

  i2c_flag_status u_fs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .code_i  (code),
    .clr_i   (flag_clr_i),
    .flag_o  (flag),
    .status_o(status_o)
  );

  assign irq_flag_o = flag;
  assign scl_hold_o = flag;

  AST_EVT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_flag_o && evt_valid_i) |=> irq_flag_o && scl_hold_o); // R1
  AST_CLR_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !evt_valid_i && !arb_lost) |=> !scl_hold_o); // R5
  AST_CLR_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && evt_valid_i) |=> irq_flag_o && status_o == STAT_IDLE); // R6
  AST_ARB_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_flag_o && master_tx_i && sda_rel_i && !sda_i && scl_i)
      |=> ##1 (!irq_flag_o || status_o == STAT_ARB)); // R7
endmodule

// File: tb/i2c_evt_status_test.sv
module i2c_evt_status_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       evt_valid_i = 1'b0, flag_clr_i = 1'b0;
  logic [2:0] evt_kind_i = '0;
  logic       master_tx_i = 1'b0, sda_rel_i = 1'b0, sda_i = 1'b1, scl_i = 1'b0;
  logic       irq_flag_o, scl_hold_o;
  logic [7:0] status_o;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  i2c_evt_status uut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code(int k);
    int hi;
    hi = (k < 6) ? k + 1 : (k == 6 ? 12 : 20);
    return 8'(hi * 8);
  endfunction

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 8'h0, 8'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R3 reset flag", {7'b0, irq_flag_o}, 8'h00);
    chk("R3 reset status", status_o, 8'hF8);
    rst_ni = 1'b1;
    tick();

    // R1 R2 R4 R5 R9: every event kind
    for (int k = 0; k < 8; k++) begin
      evt_valid_i = 1'b1; evt_kind_i = 3'(k); tick(); evt_valid_i = 1'b0;
      chk("R1 flag", {7'b0, irq_flag_o}, 8'h01);
      chk("R2 status lag", status_o, 8'hF8);
      tick();
      chk("R2 code", status_o, exp_code(k));
      chk("R9 low bits", {5'b0, status_o[2:0]}, 8'h00);
      tick(); tick();
      chk("R4 hold", {6'b0, irq_flag_o, scl_hold_o}, 8'h03);
      clear_flag();
      chk("R5 release", {6'b0, irq_flag_o, scl_hold_o}, 8'h00);
      chk("R3 idle", status_o, 8'hF8);
    end

    // R5: clear while flag low
    clear_flag();
    chk("R5 clr idle", {6'b0, irq_flag_o, scl_hold_o}, 8'h00);
    chk("R5 clr idle status", status_o, 8'hF8);

    // R8: events while set are ignored
    evt_valid_i = 1'b1; evt_kind_i = 3'd0; tick(); evt_valid_i = 1'b0; tick();
    for (int k = 1; k < 8; k++) begin
      evt_valid_i = 1'b1; evt_kind_i = 3'(k); tick(); evt_valid_i = 1'b0; tick();
      chk("R8 kept", status_o, 8'h08);
    end

    // R6: clear collides with new event
    for (int k = 0; k < 8; k++) begin
      evt_valid_i = 1'b1; evt_kind_i = 3'(k); flag_clr_i = 1'b1;
      tick(); evt_valid_i = 1'b0; flag_clr_i = 1'b0;
      chk("R6 flag", {7'b0, irq_flag_o}, 8'h01);
      chk("R6 gap", status_o, 8'hF8);
      tick();
      chk("R6 code", status_o, exp_code(k));
    end
    clear_flag();

    // R7: sweep arbitration inputs, with and without a strobe
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 16; c++) begin
        logic hit;
        master_tx_i = c[0]; sda_rel_i = c[1]; sda_i = c[2]; scl_i = c[3];
        evt_valid_i = s[0]; evt_kind_i = 3'd4;
        hit = c[0] & c[1] & ~c[2] & c[3];
        tick();
        master_tx_i = 1'b0; sda_rel_i = 1'b0; sda_i = 1'b1; scl_i = 1'b0;
        evt_valid_i = 1'b0;
        chk("R7 flag", {7'b0, irq_flag_o}, {7'b0, hit | s[0]});
        tick();
        chk("R7 code", status_o, hit ? 8'h38 : (s[0] ? 8'h28 : 8'hF8));
        clear_flag();
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule